// File: doc/BRIEF.md
# Byte-Banked Memory with Selectable Address Decode

This block is a small memory on a 20-bit address, 16-bit data bus. Its storage is two byte-wide banks that share one location index: an even bank that carries data bits 7:0 and an odd bank that carries bits 15:8. Address bit 0 and an active-low high-byte enable choose the lanes, so one access can be a full word at an even address, a single even byte, or a single odd byte. The location inside a bank comes from address bits `LOC_BITS:1`. The default `LOC_BITS` is 10, which gives 1K locations per bank. Setting it to 13 gives the full 8K-deep banks.

A static two-bit mode input picks how the upper address bits select the memory:
- **Exact match**: every upper bit must equal a fixed pattern.
- **Single-line**: only bit 19 is examined. The memory therefore answers at many alias addresses.
- **Group**: a 3-to-8 decode of three upper bits, gated by a base pattern on the bits above them, drives a one-hot select vector. The memory answers on one entry of that vector.

Writes commit on the clock edge. Read data is registered and appears one cycle after the request.

Top module: `byte_bank_mem`

## Requirements
- R1: A request with `addrIn[0]`=0 and `highEnN`=0 accesses both banks at location `addrIn[LOC_BITS:1]`. Bits 7:0 of the data belong to the even bank and bits 15:8 to the odd bank.
- R2: A request with `addrIn[0]`=1 and `highEnN`=0 accesses only the odd bank. A read returns the data on bits 15:8 with bits 7:0 at zero. A write leaves the even bank unchanged.
- R3: A request with `addrIn[0]`=0 and `highEnN`=1 accesses only the even bank. A read returns bits 15:8 as zero. A write leaves the odd bank unchanged.
- R4: A request with `addrIn[0]`=1 and `highEnN`=1 accesses neither bank. A read returns zero and a write changes nothing.
- R5: With `decodeMode`=0, `chipSel` is 1 exactly when `addrIn[19:LOC_BITS+1]` equals `FULL_MATCH`.
- R6: With `decodeMode`=1, `chipSel` is 1 exactly when `addrIn[19]`=0. Bits 18 down to `LOC_BITS+1` are ignored, so addresses that differ only there reach the same storage.
- R7: With `decodeMode`=2, `blockSel[k]` is 1 only when `addrIn[19:LOC_BITS+4]` equals `BLOCK_BASE` and `addrIn[LOC_BITS+3:LOC_BITS+1]` equals k. In that mode `chipSel` equals `blockSel[MEM_BLOCK]`. In every other mode `blockSel` is zero.
- R8: With `decodeMode`=3, neither `chipSel` nor any bit of `blockSel` is ever asserted.
- R9: Read data is registered. `rdData` shows the addressed lanes one cycle after a cycle with `rdEn`=1 and `chipSel`=1, and is zero after any other cycle. A read and a write to the same location in one cycle return the content from before the write.
- R10: When `chipSel` is 0, `wrEn` has no effect on either bank, whatever the byte enables are.
- R11: While `rstN` is low, `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| decodeMode | input | 2 | Static decode mode: 0 exact, 1 single-line, 2 group, 3 off |
| addrIn | input | 20 | Byte address |
| highEnN | input | 1 | Active-low enable of the odd (high) byte lane |
| rdEn | input | 1 | Read request |
| wrEn | input | 1 | Write request |
| wrData | input | 16 | Write data, bits 7:0 even lane, bits 15:8 odd lane |
| rdData | output | 16 | Registered read data |
| chipSel | output | 1 | Memory selected by the current address |
| blockSel | output | 8 | One-hot group select vector |

## Verification
A read and a write can fall in the same cycle on the same location, with any mix of lane enables. The random phase raises `rdEn` and `wrEn` together in a large share of cycles. A directed case does the same on a word that has already been written. The bench model computes the expected read from its copy of the storage before it applies the write. The returned word must be the old content, and a following read must show the new content.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int BLK_SEL_BITS = 3;
  localparam int NUM_BLOCKS = 1 << BLK_SEL_BITS;

  typedef enum logic [1:0] {
    MODE_EXACT  = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_GROUP  = 2'd2,
    MODE_OFF    = 2'd3
  } decodeMode_t;

  // strobes from control to datapath, one pair per lane
  typedef struct packed {
    logic rdLo;
    logic rdHi;
    logic wrLo;
    logic wrHi;
  } bankStrobe_t;

endpackage

// File: rtl/bbm_decode.sv
module bbm_decode
  import bbm_pkg::*;
#(
  parameter int LOC_BITS = 10,
  parameter logic [31:0] FULL_MATCH = 32'h0C3,
  parameter logic [31:0] BLOCK_BASE = 32'h05,
  parameter int MEM_BLOCK = 3,
  localparam int UP_LO = LOC_BITS + 1,
  localparam int UP_W = ADDR_W - UP_LO,
  localparam int BASE_W = UP_W - BLK_SEL_BITS
) (
  input  logic [1:0]            decodeMode,
  input  logic [UP_W-1:0]       upperAddr,
  input  logic                  addrLsb,
  input  logic                  highEnN,
  input  logic                  rdEn,
  input  logic                  wrEn,
  output logic                  chipSel,
  output logic [NUM_BLOCKS-1:0] blockSel,
  output bankStrobe_t           strobe
);

  localparam logic [UP_W-1:0] FULL_PAT = FULL_MATCH[UP_W-1:0];
  localparam logic [BASE_W-1:0] BASE_PAT = BLOCK_BASE[BASE_W-1:0];

  decodeMode_t modeQ;
  logic exactHit;
  logic singleHit;
  logic baseHit;
  logic [BLK_SEL_BITS-1:0] blkIdx;
  logic [NUM_BLOCKS-1:0] blkRaw;
  logic laneLo;
  logic laneHi;

  assign modeQ = decodeMode_t'(decodeMode);
  assign exactHit = (upperAddr == FULL_PAT);
  assign singleHit = ~upperAddr[UP_W-1];
  assign baseHit = (upperAddr[UP_W-1:BLK_SEL_BITS] == BASE_PAT);
  assign blkIdx = upperAddr[BLK_SEL_BITS-1:0];

  // 3-to-8 stage, gated by the base pattern
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : gBlk
    assign blkRaw[g] = baseHit && (blkIdx == BLK_SEL_BITS'(g));
  end

  always_comb begin
    chipSel = 1'b0;
    blockSel = '0;
    unique case (modeQ)
      MODE_EXACT:  chipSel = exactHit;
      MODE_SINGLE: chipSel = singleHit;
      MODE_GROUP: begin
        blockSel = blkRaw;
        chipSel = blkRaw[MEM_BLOCK];
      end
      MODE_OFF:    chipSel = 1'b0;
      default:     chipSel = 1'b0;
    endcase
  end

  assign laneLo = ~addrLsb;
  assign laneHi = ~highEnN;

  always_comb begin
    strobe.rdLo = chipSel && laneLo && rdEn;
    strobe.rdHi = chipSel && laneHi && rdEn;
    strobe.wrLo = chipSel && laneLo && wrEn;
    strobe.wrHi = chipSel && laneHi && wrEn;
  end

endmodule

// File: rtl/bbm_bank.sv
module bbm_bank
  import bbm_pkg::*;
#(
  parameter int LOC_BITS = 10,
  localparam int DEPTH = 1 << LOC_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [LOC_BITS-1:0] locIdx,
  input  logic [LANE_W-1:0] wrByte,
  output logic [LANE_W-1:0] rdByte
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrStb) mem[locIdx] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdByte <= '0;
    else if (rdStb) rdByte <= mem[locIdx];
    else rdByte <= '0;
  end

endmodule

// File: rtl/bbm_datapath.sv
module bbm_datapath
  import bbm_pkg::*;
#(
  parameter int LOC_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  bankStrobe_t         strobe,
  input  logic [LOC_BITS-1:0] locIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData
);

  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] wrStbs;
  logic [LANES-1:0] rdStbs;

  assign wrStbs = {strobe.wrHi, strobe.wrLo};
  assign rdStbs = {strobe.rdHi, strobe.rdLo};

  for (genvar l = 0; l < LANES; l++) begin : gLane
    bbm_bank #(.LOC_BITS(LOC_BITS)) uBank (
      .clk    (clk),
      .rstN   (rstN),
      .wrStb  (wrStbs[l]),
      .rdStb  (rdStbs[l]),
      .locIdx (locIdx),
      .wrByte (wrData[l*LANE_W +: LANE_W]),
      .rdByte (rdData[l*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/byte_bank_mem.sv
module byte_bank_mem
  import bbm_pkg::*;
#(
  parameter int LOC_BITS = 10,
  parameter logic [31:0] FULL_MATCH = 32'h0C3,
  parameter logic [31:0] BLOCK_BASE = 32'h05,
  parameter int MEM_BLOCK = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  decodeMode,
  input  logic [19:0] addrIn,
  input  logic        highEnN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        chipSel,
  output logic [7:0]  blockSel
);

  localparam int UP_LO = LOC_BITS + 1;

  bankStrobe_t strobe;

  bbm_decode #(
    .LOC_BITS   (LOC_BITS),
    .FULL_MATCH (FULL_MATCH),
    .BLOCK_BASE (BLOCK_BASE),
    .MEM_BLOCK  (MEM_BLOCK)
  ) uDecode (
    .decodeMode (decodeMode),
    .upperAddr  (addrIn[ADDR_W-1:UP_LO]),
    .addrLsb    (addrIn[0]),
    .highEnN    (highEnN),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .chipSel    (chipSel),
    .blockSel   (blockSel),
    .strobe     (strobe)
  );

  bbm_datapath #(.LOC_BITS(LOC_BITS)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .locIdx (addrIn[LOC_BITS:1]),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
  parameter int MEM_BLOCK = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  decodeMode,
  input logic        addrLsb,
  input logic        highEnN,
  input logic        rdEn,
  input logic        chipSel,
  input logic [7:0]  blockSel,
  input logic [15:0] rdData
);

  // R9: no read that is both requested and selected -> zero next cycle
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && chipSel) |=> rdData == 16'h0);

  // R4: no lane enabled -> read returns zero
  a_r4_no_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addrLsb && highEnN) |=> rdData == 16'h0);

  // R2: odd address -> low lane zero
  a_r2_odd_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addrLsb) |=> rdData[7:0] == 8'h0);

  // R3: high lane disabled -> high lane zero
  a_r3_even_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && highEnN) |=> rdData[15:8] == 8'h0);

  // R7: at most one group select
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blockSel));

  // R7: group mode ties chip select to the memory's entry
  a_r7_cs_group: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode == 2'd2) |-> (chipSel == blockSel[MEM_BLOCK]));

  // R7: vector idle outside group mode
  a_r7_vec_idle: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode != 2'd2) |-> (blockSel == 8'h0));

  // R8: off mode selects nothing
  a_r8_off: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode == 2'd3) |-> (!chipSel && blockSel == 8'h0));

endmodule

bind byte_bank_mem bbm_checker #(.MEM_BLOCK(MEM_BLOCK)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .decodeMode (decodeMode),
  .addrLsb    (addrIn[0]),
  .highEnN    (highEnN),
  .rdEn       (rdEn),
  .chipSel    (chipSel),
  .blockSel   (blockSel),
  .rdData     (rdData)
);

// File: tb/sim_byte_bank_mem.sv
module sim_byte_bank_mem;

  localparam int LOC = 10;
  localparam int DEPTH = 1 << LOC;
  localparam logic [8:0] FULLP = 9'h0C3;
  localparam logic [5:0] BASEP = 6'h05;
  localparam int MEMBLK = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] decodeMode = 2'd0;
  logic [19:0] addrIn = '0;
  logic highEnN = 1'b1;
  logic rdEn = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic chipSel;
  logic [7:0] blockSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mLo [DEPTH];
  logic [7:0] mHi [DEPTH];

  always #5 clk = ~clk;

  byte_bank_mem #(
    .LOC_BITS(LOC), .FULL_MATCH(32'h0C3), .BLOCK_BASE(32'h05), .MEM_BLOCK(MEMBLK)
  ) u0 (
    .clk(clk), .rstN(rstN), .decodeMode(decodeMode), .addrIn(addrIn),
    .highEnN(highEnN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .chipSel(chipSel), .blockSel(blockSel)
  );

  function automatic logic [7:0] expBlk(input logic [1:0] m, input logic [19:0] a);
    if (m == 2'd2 && a[19:14] == BASEP) return 8'(1) << a[13:11];
    return 8'h0;
  endfunction

  function automatic logic expCs(input logic [1:0] m, input logic [19:0] a);
    case (m)
      2'd0: return a[19:11] == FULLP;
      2'd1: return !a[19];
      2'd2: return expBlk(m, a)[MEMBLK];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: drive at a negedge, check decode, check read at the next negedge
  task automatic access(input logic [1:0] m, input logic [19:0] a, input logic hen,
                        input logic rd, input logic wr, input logic [15:0] d,
                        input string rdTag);
    logic cs;
    logic [15:0] exp;
    logic [LOC-1:0] idx;
    decodeMode = m; addrIn = a; highEnN = hen; rdEn = rd; wrEn = wr; wrData = d;
    #1;
    cs = expCs(m, a);
    idx = a[LOC:1];
    chk(modeTag(m), {31'b0, chipSel}, {31'b0, cs});
    chk("R7", {24'b0, blockSel}, {24'b0, expBlk(m, a)});
    exp = '0;
    if (rd && cs) begin
      if (!a[0]) exp[7:0] = mLo[idx];
      if (!hen) exp[15:8] = mHi[idx];
    end
    if (wr && cs) begin
      if (!a[0]) mLo[idx] = d[7:0];
      if (!hen) mHi[idx] = d[15:8];
    end
    @(negedge clk);
    chk(rdTag, {16'b0, rdData}, {16'b0, exp});
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  function automatic logic [19:0] fullAddr(input int i, input logic lsb);
    return {FULLP, 10'(i), lsb};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11", {16'b0, rdData}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // preload every location with word writes (R1)
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      access(2'd0, fullAddr(i, 1'b0), 1'b0, 1'b0, 1'b1, d, "R1");
    end
    // word read back
    access(2'd0, fullAddr(17, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R1");

    // odd byte write; even lane must keep its value (R2)
    access(2'd0, fullAddr(40, 1'b1), 1'b0, 1'b0, 1'b1, 16'hA55A, "R2");
    access(2'd0, fullAddr(40, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R2");
    access(2'd0, fullAddr(40, 1'b1), 1'b0, 1'b1, 1'b0, 16'h0, "R2");

    // even byte write; odd lane must keep its value (R3)
    access(2'd0, fullAddr(41, 1'b0), 1'b1, 1'b0, 1'b1, 16'h3CC3, "R3");
    access(2'd0, fullAddr(41, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R3");

    // no lane: read zero, write ignored (R4)
    access(2'd0, fullAddr(42, 1'b1), 1'b1, 1'b1, 1'b1, 16'hFFFF, "R4");
    access(2'd0, fullAddr(42, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R4");

    // single-line aliasing: write via one alias, read via another (R6)
    access(2'd1, 20'h0_0000 | (20'd55 << 1), 1'b0, 1'b0, 1'b1, 16'hBEEF, "R6");
    access(2'd1, 20'h7_C000 | (20'd55 << 1), 1'b0, 1'b1, 1'b0, 16'h0, "R6");
    access(2'd1, 20'h4_A800 | (20'd55 << 1), 1'b0, 1'b1, 1'b0, 16'h0, "R6");
    // bit 19 high deselects: write has no effect (R10)
    access(2'd1, 20'h8_0000 | (20'd55 << 1), 1'b0, 1'b1, 1'b1, 16'h1234, "R10");
    access(2'd0, fullAddr(55, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R10");

    // group mode: another block selected, memory not (R7, R10)
    access(2'd2, {BASEP, 3'd5, 10'd60, 1'b0}, 1'b0, 1'b1, 1'b1, 16'h9999, "R10");
    access(2'd2, {BASEP, 3'(MEMBLK), 10'd60, 1'b0}, 1'b0, 1'b1, 1'b0, 16'h0, "R7");
    access(2'd2, {~BASEP, 3'(MEMBLK), 10'd60, 1'b0}, 1'b0, 1'b1, 1'b0, 16'h0, "R7");

    // off mode (R8)
    access(2'd3, fullAddr(60, 1'b0), 1'b0, 1'b1, 1'b1, 16'h7777, "R8");

    // read and write of one word in the same cycle (R9)
    access(2'd0, fullAddr(70, 1'b0), 1'b0, 1'b1, 1'b1, 16'hC0DE, "R9");
    access(2'd0, fullAddr(70, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R9");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] m;
      logic [19:0] a;
      m = 2'($urandom);
      a = 20'($urandom);
      if ($urandom % 4 != 0) begin
        case (m)
          2'd0: a[19:11] = FULLP;
          2'd1: a[19] = 1'b0;
          2'd2: begin
            a[19:14] = BASEP;
            if ($urandom % 2 == 0) a[13:11] = 3'(MEMBLK);
          end
          default: ;
        endcase
      end
      access(m, a, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), "R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule